// File: doc/BRIEF.md
# Master Clock Ratio Detector

This block sits in the master clock domain. It counts how many master clock cycles pass between two rising edges of the frame clock, which is the left/right clock that runs at the sample rate. From that count it picks one of five supported master-to-frame ratios. In base-rate operation these are 256, 384 and 512. In high-rate operation they are 128 and 192. The block then drives a ratio code, a rate-mode flag and a divider setting for the clock generators downstream.

The frame clock only has to be synchronous to the master clock. No phase relationship is assumed. The block samples the frame clock through a short synchronizer and uses only its rising edges, so the duty cycle does not matter. Measurement runs on every frame. The result is only declared locked once two frames in a row give the same ratio.

A count that matches no supported ratio raises an error flag. The block then tries again on the next frame. The control and status pins are plain levels with no handshake, since no data stream passes through the block.

Top module: `mclk_ratio_detect`

## Requirements
- R1: While reset is held and right after it is released, valid_o, error_o, high_rate_o, ratio_code_o and div_o are all 0.
- R2: A measurement is the number of master clock cycles between two consecutive frame clock rising edges. The first rising edge after reset only starts counting and produces no measurement.
- R3: A measured count within 2 of 128, 192, 256, 384 or 512 is assigned ratio code 0, 1, 2, 3 or 4 (3-bit field), in that order.
- R4: When locked, high_rate_o is 1 for codes 0 and 1 and 0 for codes 2, 3 and 4.
- R5: When locked, div_o (4 bits) equals the nominal ratio divided by 64: 2, 3, 4, 6 or 8 for codes 0 to 4.
- R6: valid_o rises only after two consecutive measurements give the same code. A single in-range measurement after reset or after an error leaves valid_o at 0.
- R7: A count outside every tolerance window, including an offset of exactly 3 from a nominal value, sets error_o to 1 and valid_o to 0. The next in-range measurement clears error_o.
- R8: An in-range measurement whose code differs from the previous one drops valid_o. valid_o returns after one further measurement with the new code.
- R9: The high time of the frame clock has no effect on the result. Only the spacing of its rising edges counts.
- R10: ratio_code_o, high_rate_o and div_o change only when a lock is declared. Otherwise they keep the last locked values, including while valid_o or error_o is being updated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk_i | input | 1 | Master clock, the only clock of the block |
| rst_n_i | input | 1 | Active-low synchronous reset |
| frame_clk_i | input | 1 | Frame (left/right) clock, synchronous to mclk_i |
| ratio_code_o | output | 3 | Locked ratio code, 0..4 for 128/192/256/384/512 |
| high_rate_o | output | 1 | Locked rate mode, 1 for high-rate |
| div_o | output | 4 | Divider setting, nominal ratio / 64 |
| valid_o | output | 1 | Two consecutive frames agreed on the ratio |
| error_o | output | 1 | Last measurement matched no supported ratio |

## Verification
The assertions assume that the frame clock is a level signal that changes only between master clock edges. They also assume a frame period of at least a few cycles, so that a strobe is never followed straight away by another. The stimulus meets both assumptions: it changes the frame clock only on the falling master clock edge and never makes a frame shorter than eight cycles. Within that limit it mixes three kinds of period: counts near each nominal value with offsets up to 3, arbitrary counts, and random high times.

// File: rtl/mrd_pkg.sv
package mrd_pkg;
  localparam int NUM_RATIOS = 5;
  localparam int CODE_W     = 3;
  localparam int DIV_W      = 4;

  // nominal master clocks per frame for each ratio code
  function automatic int nominal_ratio(input int idx);
    if ((idx % 2) == 0) return 128 << (idx / 2);
    else                return 192 << (idx / 2);
  endfunction

  function automatic int divider_of(input int idx);
    return nominal_ratio(idx) / 64;
  endfunction
endpackage

// File: rtl/mrd_frame_sync.sv
module mrd_frame_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_clk_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= frame_clk_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (!rst_n) sync_q[s] <= 1'b0;
          else        sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/mrd_period_counter.sv
module mrd_period_counter #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  output logic             meas_stb_o,
  output logic [CNT_W-1:0] meas_cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      armed_q    <= 1'b0;
      meas_stb_o <= 1'b0;
      meas_cnt_o <= '0;
    end else begin
      meas_stb_o <= 1'b0;
      if (rise_i) begin
        if (armed_q) begin
          meas_stb_o <= 1'b1;
          meas_cnt_o <= cnt_q;
        end
        armed_q <= 1'b1;
        cnt_q   <= CNT_ONE;
      end else if (cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + CNT_ONE;
      end
    end
  end

  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rise_i) |-> cnt_q == CNT_ONE); // R2
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    meas_stb_o |=> !meas_stb_o); // R2
endmodule

// File: rtl/mrd_ratio_classifier.sv
module mrd_ratio_classifier
  import mrd_pkg::*;
#(
  parameter int CNT_W = 11,
  parameter int TOL   = 2
) (
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              hit_o,
  output logic [CODE_W-1:0] code_o
);
  logic [NUM_RATIOS-1:0] win_hit;

  generate
    for (genvar i = 0; i < NUM_RATIOS; i++) begin : g_win
      localparam logic [CNT_W-1:0] LO = CNT_W'(nominal_ratio(i) - TOL);
      localparam logic [CNT_W-1:0] HI = CNT_W'(nominal_ratio(i) + TOL);
      assign win_hit[i] = (cnt_i >= LO) && (cnt_i <= HI);
    end
  endgenerate

  // lowest matching window wins if tolerances were ever made to overlap
  always_comb begin
    hit_o  = 1'b0;
    code_o = '0;
    for (int i = NUM_RATIOS - 1; i >= 0; i--) begin
      if (win_hit[i]) begin
        hit_o  = 1'b1;
        code_o = CODE_W'(i);
      end
    end
  end
endmodule

// File: rtl/mrd_lock_tracker.sv
module mrd_lock_tracker
  import mrd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              meas_stb_i,
  input  logic              hit_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] ratio_code_o,
  output logic              high_rate_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              valid_o,
  output logic              error_o
);
  logic [CODE_W-1:0] prev_code_q;
  logic              prev_ok_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_code_q  <= '0;
      prev_ok_q    <= 1'b0;
      ratio_code_o <= '0;
      high_rate_o  <= 1'b0;
      div_o        <= '0;
      valid_o      <= 1'b0;
      error_o      <= 1'b0;
    end else if (meas_stb_i) begin
      if (!hit_i) begin
        error_o   <= 1'b1;
        valid_o   <= 1'b0;
        prev_ok_q <= 1'b0;
      end else begin
        error_o     <= 1'b0;
        prev_code_q <= code_i;
        prev_ok_q   <= 1'b1;
        if (prev_ok_q && (prev_code_q == code_i)) begin
          valid_o      <= 1'b1;
          ratio_code_o <= code_i;
          high_rate_o  <= (code_i < CODE_W'(2));
          div_o        <= DIV_W'(divider_of(int'(code_i)));
        end else begin
          valid_o <= 1'b0;
        end
      end
    end
  end

  AST_VALID_NOT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> !error_o); // R7
  AST_RATE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (high_rate_o == (ratio_code_o <= CODE_W'(1)))); // R4
  AST_VALID_FROM_MEAS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> $past(meas_stb_i) && $past(prev_ok_q)); // R6
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(meas_stb_i) |-> $stable(ratio_code_o) && $stable(div_o)); // R10
  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_code_o <= CODE_W'(NUM_RATIOS - 1)); // R3
endmodule

// File: rtl/mclk_ratio_detect.sv
module mclk_ratio_detect
  import mrd_pkg::*;
#(
  parameter int CNT_W       = 11,
  parameter int TOL         = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              mclk_i,
  input  logic              rst_n_i,
  input  logic              frame_clk_i,
  output logic [CODE_W-1:0] ratio_code_o,
  output logic              high_rate_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              valid_o,
  output logic              error_o
);
  logic              rise;
  logic              meas_stb;
  logic [CNT_W-1:0]  meas_cnt;
  logic              cls_hit;
  logic [CODE_W-1:0] cls_code;

  mrd_frame_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(mclk_i), .rst_n(rst_n_i), .frame_clk_i(frame_clk_i), .rise_o(rise)
  );

  mrd_period_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(mclk_i), .rst_n(rst_n_i), .rise_i(rise),
    .meas_stb_o(meas_stb), .meas_cnt_o(meas_cnt)
  );

  mrd_ratio_classifier #(.CNT_W(CNT_W), .TOL(TOL)) u_cls (
    .cnt_i(meas_cnt), .hit_o(cls_hit), .code_o(cls_code)
  );

  mrd_lock_tracker u_lock (
    .clk(mclk_i), .rst_n(rst_n_i), .meas_stb_i(meas_stb),
    .hit_i(cls_hit), .code_i(cls_code),
    .ratio_code_o(ratio_code_o), .high_rate_o(high_rate_o), .div_o(div_o),
    .valid_o(valid_o), .error_o(error_o)
  );

  AST_ERR_NEEDS_MEAS: assert property (@(posedge mclk_i) disable iff (!rst_n_i)
    $rose(error_o) |-> $past(meas_stb)); // R7
endmodule

// File: tb/mclk_ratio_detect_tb.sv
module mclk_ratio_detect_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fclk = 1'b0;
  logic [2:0] code;
  logic       hr;
  logic [3:0] div;
  logic       valid;
  logic       err;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // model state
  bit m_armed = 0, m_prev_ok = 0, m_valid = 0, m_err = 0, m_hr = 0;
  int m_prev = 0, m_code = 0, m_div = 0, prev_period = 0;

  always #10 clk = ~clk;

  mclk_ratio_detect u_dut (
    .mclk_i(clk), .rst_n_i(rst_n), .frame_clk_i(fclk),
    .ratio_code_o(code), .high_rate_o(hr), .div_o(div),
    .valid_o(valid), .error_o(err)
  );

  function automatic int nom(input int c);
    case (c)
      0: return 128;
      1: return 192;
      2: return 256;
      3: return 384;
      default: return 512;
    endcase
  endfunction

  function automatic int classify(input int n);
    for (int c = 0; c < 5; c++)
      if (n >= nom(c) - 2 && n <= nom(c) + 2) return c;
    return -1;
  endfunction

  task automatic model_meas(input int n);
    int c;
    c = classify(n);
    if (c < 0) begin
      m_err = 1; m_valid = 0; m_prev_ok = 0;
    end else begin
      m_err = 0;
      if (m_prev_ok && m_prev == c) begin
        m_valid = 1; m_code = c; m_hr = (c < 2); m_div = nom(c) / 64;
      end else begin
        m_valid = 0;
      end
      m_prev = c; m_prev_ok = 1;
    end
  endtask

  task automatic check(input string tag);
    n_tests++;
    if (valid !== m_valid || err !== m_err || code !== 3'(m_code) ||
        hr !== m_hr || div !== 4'(m_div)) begin
      n_fail++;
      $display("FAIL %s: got v=%0b e=%0b code=%0d hr=%0b div=%0d, expected v=%0b e=%0b code=%0d hr=%0b div=%0d",
               tag, valid, err, code, hr, div, m_valid, m_err, m_code, m_hr, m_div);
    end
  endtask

  // one frame: rising edge, high for h cycles, total p cycles
  task automatic frame(input int p, input int h, input string tag);
    int old;
    old = prev_period;
    prev_period = p;
    fclk = 1'b1;
    for (int i = 0; i < p; i++) begin
      @(negedge clk);
      if (i + 1 == h) fclk = 1'b0;
      if (i == 3) begin
        if (m_armed) model_meas(old);
        m_armed = 1;
        check(tag);
      end
    end
  endtask

  initial begin
    int p, h, r;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after reset");

    frame(256, 128, "R2 first edge arms only");
    frame(256, 100, "R6 single measurement");
    frame(256, 30,  "R3 code 2");
    frame(256, 250, "R5 div 4 / R9 duty");
    frame(128, 64,  "R4 still 256 lock");
    frame(128, 1,   "R8 change drops valid");
    frame(128, 127, "R4 high rate code 0");
    frame(192, 90,  "R5 div 2");
    frame(192, 5,   "R8 change to 192");
    frame(384, 190, "R4 high rate code 1");
    frame(384, 190, "R8 change to 384");
    frame(512, 256, "R5 div 6");
    frame(512, 300, "R8 change to 512");
    frame(514, 10,  "R5 div 8");
    frame(510, 200, "R3 upper edge 514");
    frame(515, 200, "R3 lower edge 510");
    frame(253, 100, "R7 offset 3 error, R10 hold");
    frame(258, 100, "R7 offset -3 error");
    frame(254, 100, "R7 first ok clears error");
    frame(300, 100, "R6 258 then 254 locks");
    frame(129, 20,  "R7 300 is error");
    frame(127, 20,  "R7 error clears");
    frame(64,  20,  "R6 127 after 129 locks");
    frame(64,  20,  "R7 64 error");

    for (int k = 0; k < 120; k++) begin
      r = int'($urandom % 10);
      if (r < 7) p = nom(int'($urandom % 5)) + int'($urandom % 7) - 3;
      else       p = 8 + int'($urandom % 700);
      h = 1 + int'($urandom % (p - 1));
      frame(p, h, "R3 random");
    end
    frame(256, 50, "R9 random tail");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule